// File: doc/BRIEF.md
# Varactor Trim Converter Command Receiver

This block is the serial-bus front end of a three-channel trim converter section in a tuner controller. It listens on a two-wire I2C bus as a write-only slave at an address of its own, separate from the synthesizer logic that shares the bus. Two strap pins pick one of four write addresses. After its address is acknowledged, each data byte names its own destination in its two top bits. It can load one of three sign-magnitude offset codes, or a range code that all three channels share.

Bytes may come in any order, and the same channel may be loaded several times in one transfer. Each accepted byte takes effect at once and raises a one-cycle update pulse. A transfer carries at most four data bytes; bytes beyond that are refused. For each channel the block also presents the offset as a two's-complement step count, and for the range it gives the raw code and a rank of the step size. The analog conversion is handled outside this block.

Top module: `vtrim_dac_rx`

## Requirements
- R1: After reset every channel code and the range code are zero, the update pulse is low and SDA is released (step rank output 3).
- R2: Only the address byte equal to {1100, strap[1:0], 1, 0} is acknowledged. Any other address byte, including the same address with the read bit set, is refused, and the data bytes that follow it are refused and change nothing.
- R3: Bits 7:6 of a data byte select the destination: 00 channel 0, 01 channel 1, 10 channel 2, 11 the range register. Only that register changes.
- R4: In a channel byte, bit 5 is the sign (1 positive, 0 negative) and bits 4:0 the magnitude. The channel's 6-bit field in conv_code_o (channel c at bits 6c+5:6c) takes byte bits 5:0.
- R5: The 6-bit field of channel c in conv_steps_o is +magnitude for sign 1 and −magnitude (two's complement) for sign 0. It is 0 whenever the magnitude is 0, whatever the sign.
- R6: In a range byte, bits 1:0 become range_code_o ({S1,S0}) and bits 5:2 are ignored. Codes 00, 01, 10 and 11 mean 225, 125, 70 and 40 mV steps. step_idx_o ranks the step from finest (0 = 40 mV) to coarsest (3 = 225 mV), i.e. the bitwise inverse of the code.
- R7: upd_o pulses for exactly one cycle per accepted data byte, in the same cycle in which the new value first appears on the outputs.
- R8: At most four data bytes per transfer are acknowledged and committed. Any further byte is refused with no pulse and no change. A START or STOP restarts the count.
- R9: Bytes are accepted in any order. A channel written repeatedly in one transfer pulses each time, and the last value stays.
- R10: A byte cut short by a STOP or START before its eighth bit is dropped: no pulse, no change, no acknowledge.
- R11: The block pulls SDA low only during the ninth clock of an accepted byte and releases it at the falling SCL edge that ends that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 2 | Address strap, becomes address bits 3:2 |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) when 1 |
| upd_o | output | 1 | One-cycle pulse per committed data byte |
| conv_code_o | output | 18 | Three 6-bit sign-magnitude channel codes |
| conv_steps_o | output | 18 | Three 6-bit two's-complement step counts |
| range_code_o | output | 2 | Shared range code {S1,S0} |
| step_idx_o | output | 2 | Step size rank, 0 finest to 3 coarsest |

## Verification
Two things happen on the same byte-complete cycle. The fourth data byte of a transfer is committed and strobed, and the byte budget is used up, so the next byte must be refused. The bench provokes this by sending five and six data bytes in one transfer. The scoreboard must see exactly four update pulses, each carrying the predicted register contents. The ninth-clock sample of the later bytes must read a NACK, and a port comparison after the STOP must show that nothing else changed. A second case lets a START arrive in the middle of a byte that follows a committed one. The commit must stand and the partial byte must leave no pulse.

// File: rtl/vtrim_pkg.sv
// Shared widths, function codes and helpers for the trim converter receiver.
package vtrim_pkg;
    localparam int MAG_W  = 5;
    localparam int CODE_W = MAG_W + 1;
    localparam int FN_W   = 2;

    typedef enum logic [FN_W-1:0] {
        FN_CH0   = 2'd0,
        FN_CH1   = 2'd1,
        FN_CH2   = 2'd2,
        FN_RANGE = 2'd3
    } fn_e;

    // Convert a sign-magnitude code into a two's-complement step count.
    function automatic logic [CODE_W-1:0] code_to_steps(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] mag;
        mag = {1'b0, code[MAG_W-1:0]};
        if (code[MAG_W]) return mag;
        return -mag;
    endfunction
endpackage

// File: rtl/vtrim_bit_rx.sv
// Bus bit and byte framer.
// Synchronises SCL/SDA, detects START/STOP, shifts in bytes MSB first and
// runs the acknowledge slot. Assumes the clock oversamples SCL by at least
// eight times. The accept decision arrives on ack_req_i while byte_valid_o is high.
module vtrim_bit_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              ack_req_i,
    output logic              sda_oe_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              first_o,
    output logic              start_o,
    output logic              stop_o
);
    localparam int BCNT_W = $clog2(BYTE_W + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);
    localparam logic [BCNT_W-1:0] FULL     = BCNT_W'(BYTE_W);

    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_s, sda_s, scl_q, sda_q;
    logic scl_rise, scl_fall;
    logic active, ack_slot, ack_want;
    logic [BCNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg;

    // Bring the asynchronous bus lines into the clock domain (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s    = scl_pipe[SYNC_STAGES-1];
    assign sda_s    = sda_pipe[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_o  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o   = scl_s & scl_q & ~sda_q & sda_s;

    // Frame bits into bytes and drive the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            bitcnt       <= '0;
            shreg        <= '0;
            first_o      <= 1'b1;
            ack_slot     <= 1'b0;
            ack_want     <= 1'b0;
            sda_oe_o     <= 1'b0;
            byte_valid_o <= 1'b0;
        end else begin
            byte_valid_o <= 1'b0;
            if (start_o) begin
                active   <= 1'b1;
                bitcnt   <= '0;
                first_o  <= 1'b1;
                ack_slot <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (stop_o) begin
                active   <= 1'b0;
                bitcnt   <= '0;
                first_o  <= 1'b1;
                ack_slot <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (active) begin
                if (scl_rise && !ack_slot && bitcnt < FULL) begin
                    shreg        <= {shreg[BYTE_W-2:0], sda_s};
                    bitcnt       <= bitcnt + 1'b1;
                    byte_valid_o <= (bitcnt == LAST_BIT);
                end
                if (byte_valid_o) begin
                    ack_want <= ack_req_i;
                end
                if (scl_fall) begin
                    if (ack_slot) begin
                        ack_slot <= 1'b0;
                        sda_oe_o <= 1'b0;
                        bitcnt   <= '0;
                        first_o  <= 1'b0;
                    end else if (bitcnt == FULL) begin
                        ack_slot <= 1'b1;
                        sda_oe_o <= ack_want;
                    end
                end
            end
        end
    end

    assign byte_o = shreg;

    AST_OE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> ack_slot);  // R11
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);  // R7
endmodule

// File: rtl/vtrim_frame_ctl.sv
// Transfer controller.
// Matches the address byte against the strap, counts the data bytes of one
// transfer and issues a write enable for each byte within the budget.
// Assumes byte_valid_i is a single-cycle pulse from the framer.
module vtrim_frame_ctl #(
    parameter int          BYTE_W    = 8,
    parameter int          MAX_BYTES = 4,
    parameter logic [3:0]  ADDR_HI   = 4'b1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              first_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              ack_req_o,
    output logic              wr_en_o
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);

    logic             addressed;
    logic [CNT_W-1:0] cnt;
    logic             addr_match, room;

    assign addr_match = (byte_i == {ADDR_HI, strap_i, 1'b1, 1'b0});
    assign room       = (cnt < CNT_MAX);
    assign ack_req_o  = first_i ? addr_match : (addressed && room);
    assign wr_en_o    = byte_valid_i && !first_i && addressed && room;

    // Track addressing and the per-transfer byte budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addressed <= 1'b0;
            cnt       <= '0;
        end else if (start_i || stop_i) begin
            addressed <= 1'b0;
            cnt       <= '0;
        end else if (byte_valid_i && first_i) begin
            addressed <= addr_match;
            cnt       <= '0;
        end else if (wr_en_o) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);  // R8
    AST_WR_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> addressed);  // R2
endmodule

// File: rtl/vtrim_reg_bank.sv
// Channel and range registers.
// Decodes the function field of a committed byte, loads the selected code,
// pulses the update strobe and derives step counts and the step rank.
// Assumes NCONV is at most three, so code 11 always means the range.
module vtrim_reg_bank
    import vtrim_pkg::*;
#(
    parameter int NCONV  = 3,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [BYTE_W-1:0]       wr_byte_i,
    output logic                    upd_o,
    output logic [NCONV*CODE_W-1:0] conv_code_o,
    output logic [NCONV*CODE_W-1:0] conv_steps_o,
    output logic [1:0]              range_code_o,
    output logic [1:0]              step_idx_o
);
    logic [NCONV-1:0][CODE_W-1:0] codes_q;
    logic [1:0]                   range_q;
    fn_e                          fsel;

    assign fsel = fn_e'(wr_byte_i[BYTE_W-1 -: FN_W]);

    generate
        for (genvar c = 0; c < NCONV; c++) begin : g_ch
            // Load this channel's code when its function code is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    codes_q[c] <= '0;
                end else if (wr_en_i && fsel == fn_e'(c)) begin
                    codes_q[c] <= wr_byte_i[CODE_W-1:0];
                end
            end

            assign conv_steps_o[c*CODE_W +: CODE_W] = code_to_steps(codes_q[c]);

            AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
                (conv_code_o[c*CODE_W +: MAG_W] == '0)
                    |-> (conv_steps_o[c*CODE_W +: CODE_W] == '0));  // R5
        end
    endgenerate

    // Load the shared range code and raise the per-byte update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= '0;
            upd_o   <= 1'b0;
        end else begin
            upd_o <= wr_en_i;
            if (wr_en_i && fsel == FN_RANGE) begin
                range_q <= wr_byte_i[1:0];
            end
        end
    end

    assign conv_code_o  = codes_q;
    assign range_code_o = range_q;
    assign step_idx_o   = ~range_q;

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(conv_code_o) && $stable(range_code_o)));  // R3
endmodule

// File: rtl/vtrim_dac_rx.sv
// Top of the trim converter command receiver.
// Joins the bus framer, transfer controller and register bank. Assumes the
// bus is oversampled by clk and that SDA is wired-AND with sda_oe_o outside.
module vtrim_dac_rx
    import vtrim_pkg::*;
#(
    parameter int NCONV     = 3,
    parameter int MAX_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [1:0]              strap_i,
    output logic                    sda_oe_o,
    output logic                    upd_o,
    output logic [NCONV*CODE_W-1:0] conv_code_o,
    output logic [NCONV*CODE_W-1:0] conv_steps_o,
    output logic [1:0]              range_code_o,
    output logic [1:0]              step_idx_o
);
    localparam int BYTE_W = 8;

    logic              byte_valid, first, bus_start, bus_stop, ack_req, wr_en;
    logic [BYTE_W-1:0] rx_byte;

    vtrim_bit_rx #(.SYNC_STAGES(2), .BYTE_W(BYTE_W)) u_bit_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_i),
        .sda_i        (sda_i),
        .ack_req_i    (ack_req),
        .sda_oe_o     (sda_oe_o),
        .byte_valid_o (byte_valid),
        .byte_o       (rx_byte),
        .first_o      (first),
        .start_o      (bus_start),
        .stop_o       (bus_stop)
    );

    vtrim_frame_ctl #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_i      (strap_i),
        .byte_valid_i (byte_valid),
        .byte_i       (rx_byte),
        .first_i      (first),
        .start_i      (bus_start),
        .stop_i       (bus_stop),
        .ack_req_o    (ack_req),
        .wr_en_o      (wr_en)
    );

    vtrim_reg_bank #(.NCONV(NCONV), .BYTE_W(BYTE_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_byte_i    (rx_byte),
        .upd_o        (upd_o),
        .conv_code_o  (conv_code_o),
        .conv_steps_o (conv_steps_o),
        .range_code_o (range_code_o),
        .step_idx_o   (step_idx_o)
    );

    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);  // R7
endmodule

// File: tb/vtrim_dac_rx_bench.sv
module vtrim_dac_rx_bench;
    localparam int H = 20;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic sda_oe, upd;
    logic [17:0] code, steps;
    logic [1:0] rcode, sidx;
    logic sda_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0] mdl_code [3];
    logic [1:0] mdl_range;
    logic [19:0] exp_q [$];

    always #5 clk = ~clk;
    assign sda_w = sda_m & ~sda_oe;

    vtrim_dac_rx u_vtrim_dac_rx (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .strap_i(strap),
        .sda_oe_o(sda_oe), .upd_o(upd), .conv_code_o(code), .conv_steps_o(steps),
        .range_code_o(rcode), .step_idx_o(sidx)
    );

    function automatic logic [5:0] steps_of(input logic [5:0] c);
        logic [5:0] m;
        m = {1'b0, c[4:0]};
        return c[5] ? m : 6'(0 - m);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        @(negedge clk);
        chk(code == {mdl_code[2], mdl_code[1], mdl_code[0]}, req, "codes",
            32'(code), 32'({mdl_code[2], mdl_code[1], mdl_code[0]}));
        chk(steps == {steps_of(mdl_code[2]), steps_of(mdl_code[1]), steps_of(mdl_code[0])},
            req, "steps", 32'(steps),
            32'({steps_of(mdl_code[2]), steps_of(mdl_code[1]), steps_of(mdl_code[0])}));
        chk(rcode == mdl_range && sidx == ~mdl_range, req, "range",
            32'({rcode, sidx}), 32'({mdl_range, ~mdl_range}));
        chk(upd == 1'b0 && sda_oe == 1'b0, req, "idle lines", 32'({upd, sda_oe}), 32'(0));
    endtask

    // Scoreboard monitor: every pulse must match the next predicted state.
    always @(negedge clk) begin
        if (rst_n && upd) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected update pulse", 32'(code), 32'(0));
            end else begin
                logic [19:0] it;
                logic [17:0] es;
                it = exp_q.pop_front();
                es = {steps_of(it[17:12]), steps_of(it[11:6]), steps_of(it[5:0])};
                chk(code == it[17:0], "R4", "codes at pulse", 32'(code), 32'(it[17:0]));
                chk(steps == es, "R5", "steps at pulse", 32'(steps), 32'(es));
                chk(rcode == it[19:18] && sidx == ~it[19:18], "R6", "range at pulse",
                    32'({rcode, sidx}), 32'({it[19:18], ~it[19:18]}));
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; repeat (H) @(posedge clk);
        scl_m = 1'b1; repeat (H) @(posedge clk);
        sda_m = 1'b0; repeat (H) @(posedge clk);
        scl_m = 1'b0; repeat (Q) @(posedge clk);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; repeat (H) @(posedge clk);
        scl_m = 1'b1; repeat (H) @(posedge clk);
        sda_m = 1'b1; repeat (H) @(posedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    repeat (H) @(posedge clk);
        scl_m = 1'b1; repeat (H) @(posedge clk);
        scl_m = 1'b0; repeat (Q) @(posedge clk);
    endtask

    // Driver: predicts the commit, pushes it, sends the byte, checks the acknowledge.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input bit commit, input string req);
        logic got;
        if (commit) begin
            if (b[7:6] == 2'b11) mdl_range = b[1:0];
            else mdl_code[b[7:6]] = b[5:0];
            exp_q.push_back({mdl_range, mdl_code[2], mdl_code[1], mdl_code[0]});
        end
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; repeat (H) @(posedge clk);
        scl_m = 1'b1; repeat (H/2) @(posedge clk);
        @(negedge clk); got = ~sda_w;
        repeat (H/2) @(posedge clk);
        scl_m = 1'b0; repeat (Q) @(posedge clk);
        chk(got == exp_ack, req, $sformatf("ack for byte %02h", b), 32'(got), 32'(exp_ack));
        if (exp_ack) begin
            @(negedge clk);
            chk(sda_oe == 1'b0, "R11", "sda released after ack", 32'(sda_oe), 32'(0));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) mdl_code[i] = '0;
        mdl_range = '0;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        check_state("R1");

        // R3 R4 R5 R6: one byte per destination, range byte with junk in bits 5:2
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_byte(8'h25, 1, 1, "R3");
        send_byte(8'h5F, 1, 1, "R4");
        send_byte(8'h9F, 1, 1, "R5");
        send_byte(8'hFE, 1, 1, "R6");
        bus_stop();
        check_state("R6");

        // R8: budget of four, zero magnitudes with either sign, fifth and sixth refused
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_byte(8'h00, 1, 1, "R5");
        send_byte(8'h60, 1, 1, "R5");
        send_byte(8'hC1, 1, 1, "R6");
        send_byte(8'h81, 1, 1, "R8");
        send_byte(8'h3F, 0, 0, "R8");
        send_byte(8'hC3, 0, 0, "R8");
        bus_stop();
        check_state("R8");

        // R9: same channel four times, last value stays
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_byte(8'h01, 1, 1, "R9");
        send_byte(8'h02, 1, 1, "R9");
        send_byte(8'h03, 1, 1, "R9");
        send_byte(8'h2A, 1, 1, "R9");
        bus_stop();
        check_state("R9");

        // R2: foreign write address and own read address are refused
        bus_start();
        send_byte(8'hC2, 0, 0, "R2");
        send_byte(8'h15, 0, 0, "R2");
        bus_stop();
        bus_start();
        send_byte(8'hCB, 0, 0, "R2");
        send_byte(8'h55, 0, 0, "R2");
        bus_stop();
        check_state("R2");

        // R10: byte cut by STOP, then byte cut by repeated START after a commit
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        check_state("R10");
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_byte(8'h11, 1, 1, "R10");
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_byte(8'h55, 1, 1, "R10");
        bus_stop();
        check_state("R10");

        // R8: repeated START restarts the byte budget
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_byte(8'h84, 1, 1, "R8");
        send_byte(8'h44, 1, 1, "R8");
        send_byte(8'h04, 1, 1, "R8");
        send_byte(8'hC2, 1, 1, "R8");
        bus_start();
        send_byte(8'hCA, 1, 0, "R2");
        send_byte(8'hA0, 1, 1, "R8");
        bus_stop();
        check_state("R8");

        repeat (10) @(posedge clk);
        chk(exp_q.size() == 0, "R7", "missing update pulses", 32'(exp_q.size()), 32'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule